// File: doc/BRIEF.md
# Write-Protected Register Guard

This block holds a single control register whose contents may only be replaced through a fixed unlock ritual on a simple register bus. Software writes the unlock key to a command address. It then writes the desired value to the guarded address, followed by the bitwise complement of that value, and then the value once more. The guarded register takes the new contents only when that last write arrives. Until then its previous contents are kept.

The command address and the guarded address together form the protected group. Once the key has been accepted, any read or write to either group address that is not the expected next step breaks the sequence. A broken sequence returns the guard to its idle state and sets a sticky error flag. Software reads that flag at a separate status address, which lies outside the group, to confirm whether the update succeeded.

Bus traffic to any other address never disturbs the sequence. A debug-halt input freezes the sequence while it is high. Group accesses made during a halt are then ignored completely.

Top module: `prot_write_guard`

## Requirements
- R1: A write of 0xA5 to the command address (0x10) while the guard is idle arms the sequence. A write of any other value there while idle leaves the guard idle and leaves the error flag unchanged.
- R2: The guarded register (address 0x14) changes only on the write that completes key, value, complement, value. It shows the new value in the cycle after that final write. Writes outside a completed sequence leave it unchanged.
- R3: After the key, any read or write to 0x10 or 0x14 that is not the expected next step aborts the sequence and sets the error flag to 1. This includes a second key write.
- R4: After an abort no progress is kept. A value, complement, value series without a fresh key does not update the register.
- R5: A completed sequence leaves the error flag at 0. The flag is visible on `seq_error` and as bit 0 of a read from the status address 0x18; the other status bits read 0.
- R6: Reads and writes to any address other than 0x10 and 0x14, including 0x18, never change the sequence progress or the error flag.
- R7: While `dbg_halt` is 1, the sequence progress, the error flag and the guarded register hold their values, and group accesses have no effect.
- R8: A complement write that is not the bitwise inverse of the first value, or a final write that differs from the first value, aborts the sequence and sets the error flag to 1.
- R9: A key write that arms the sequence clears the error flag to 0 in the following cycle.
- R10: After reset the guard is idle, the error flag is 0 and the guarded register holds 0x3C.
- R11: A read of 0x14 returns the guarded register. A read of 0x10 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_halt | input | 1 | Debug halt; freezes the sequence while high |
| bus_valid | input | 1 | Bus access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| prot_value | output | 8 | Current contents of the guarded register |
| seq_error | output | 1 | Sticky sequence error flag |

## Verification
The embedded assertions check the following on every cycle:
- Accesses outside the group leave the sequence progress and the error flag untouched.
- A halt freezes the state, the flag and the register.
- The register changes only right after a write to its address that carries the new value.
- An arming key clears the flag, a stray command read aborts, and a completed sequence leaves the flag clear.

Other behaviour can only be shown by the bench's directed scenarios:
- The full ordering rule: every abort path, mismatched complements and final values.
- That progress is lost after an abort.
- That a wrong key is ignored.
- That a sequence interrupted by a halt with group traffic still completes.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;

    localparam int KEY_W = 8;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 8'hA5;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_KEYED       = 2'd1,
        ST_GOT_VALUE   = 2'd2,
        ST_GOT_INVERSE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic cmd_wr;
        logic cmd_rd;
        logic prot_wr;
        logic prot_rd;
        logic stat_rd;
    } acc_kind_t;

    function automatic logic is_group(acc_kind_t a);
        return a.cmd_wr | a.cmd_rd | a.prot_wr | a.prot_rd;
    endfunction

endpackage

// File: rtl/prot_seq_decode.sv
module prot_seq_decode
    import prot_seq_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h10,
    parameter logic [ADDR_W-1:0] PROT_ADDR = 8'h14,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h18
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         acc
);
    logic hit_cmd, hit_prot, hit_stat;

    always_comb begin
        hit_cmd     = valid && (addr == CMD_ADDR);
        hit_prot    = valid && (addr == PROT_ADDR);
        hit_stat    = valid && (addr == STAT_ADDR);
        acc.cmd_wr  = hit_cmd  &&  write;
        acc.cmd_rd  = hit_cmd  && !write;
        acc.prot_wr = hit_prot &&  write;
        acc.prot_rd = hit_prot && !write;
        acc.stat_rd = hit_stat && !write;
    end
endmodule

// File: rtl/prot_seq_fsm.sv
module prot_seq_fsm
    import prot_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    input  acc_kind_t         acc,
    input  logic [DATA_W-1:0] wdata,
    output logic              err,
    output logic              commit,
    output logic [DATA_W-1:0] commit_data
);
    localparam logic [DATA_W-1:0] KEY_EXT = DATA_W'(UNLOCK_KEY);

    seq_state_e        state_q, state_n;
    logic              err_n;
    logic [DATA_W-1:0] cap_q, cap_n;
    logic              grp;

    assign grp         = is_group(acc);
    assign commit_data = cap_q;

    always_comb begin
        state_n = state_q;
        err_n   = err;
        cap_n   = cap_q;
        commit  = 1'b0;
        if (!halt && grp) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (acc.cmd_wr && wdata == KEY_EXT) begin
                        state_n = ST_KEYED;
                        err_n   = 1'b0;
                    end
                end
                ST_KEYED: begin
                    if (acc.prot_wr) begin
                        state_n = ST_GOT_VALUE;
                        cap_n   = wdata;
                    end else begin
                        state_n = ST_IDLE;
                        err_n   = 1'b1;
                    end
                end
                ST_GOT_VALUE: begin
                    if (acc.prot_wr && wdata == ~cap_q) begin
                        state_n = ST_GOT_INVERSE;
                    end else begin
                        state_n = ST_IDLE;
                        err_n   = 1'b1;
                    end
                end
                ST_GOT_INVERSE: begin
                    state_n = ST_IDLE;
                    if (acc.prot_wr && wdata == cap_q) begin
                        commit = 1'b1;
                    end else begin
                        err_n = 1'b1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            err     <= 1'b0;
            cap_q   <= '0;
        end else begin
            state_q <= state_n;
            err     <= err_n;
            cap_q   <= cap_n;
        end
    end

    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !grp |=> $stable(state_q) && $stable(err)); // R6
    AST_HALT_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        halt |=> $stable(state_q) && $stable(cap_q)); // R7
    AST_KEY_ARMS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !halt && acc.cmd_wr && wdata == KEY_EXT)
        |=> (state_q == ST_KEYED) && !err); // R9
    AST_STRAY_READ_ABORTS: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && !halt && acc.cmd_rd)
        |=> (state_q == ST_IDLE) && err); // R3
    AST_SUCCESS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        commit |=> !err); // R5
endmodule

// File: rtl/prot_seq_store.sv
module prot_seq_store #(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] RESET_VAL = 8'h3C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= RESET_VAL;
        else if (load) q <= load_data;
    end
endmodule

// File: rtl/prot_write_guard.sv
module prot_write_guard
    import prot_seq_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h10,
    parameter logic [ADDR_W-1:0] PROT_ADDR = 8'h14,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h18,
    parameter logic [DATA_W-1:0] RESET_VAL = 8'h3C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_halt,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] prot_value,
    output logic              seq_error
);
    acc_kind_t         acc;
    logic              commit;
    logic [DATA_W-1:0] commit_data;

    prot_seq_decode #(
        .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR),
        .PROT_ADDR(PROT_ADDR), .STAT_ADDR(STAT_ADDR)
    ) u_decode (
        .valid(bus_valid), .write(bus_write), .addr(bus_addr), .acc(acc)
    );

    prot_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst(rst), .halt(dbg_halt), .acc(acc), .wdata(bus_wdata),
        .err(seq_error), .commit(commit), .commit_data(commit_data)
    );

    prot_seq_store #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) u_store (
        .clk(clk), .rst(rst), .load(commit), .load_data(commit_data),
        .q(prot_value)
    );

    always_comb begin
        if (bus_addr == PROT_ADDR)      bus_rdata = prot_value;
        else if (bus_addr == STAT_ADDR) bus_rdata = DATA_W'(seq_error);
        else                            bus_rdata = '0;
    end

    AST_UPDATE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(prot_value) |->
            $past(bus_valid && bus_write && bus_addr == PROT_ADDR && !dbg_halt)
            && prot_value == $past(bus_wdata)); // R2
    AST_HALT_FREEZES_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        dbg_halt |=> $stable(prot_value) && $stable(seq_error)); // R7
endmodule

// File: tb/test_prot_write_guard.sv
module test_prot_write_guard;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dbg_halt = 1'b0;
    logic       bus_valid = 1'b0;
    logic       bus_write = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, prot_value;
    logic       seq_error;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    localparam logic [7:0] A_CMD = 8'h10, A_PROT = 8'h14, A_STAT = 8'h18, A_OTHER = 8'h20;

    always #10 clk = ~clk;

    prot_write_guard i_prot_write_guard (
        .clk(clk), .rst(rst), .dbg_halt(dbg_halt),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prot_value(prot_value), .seq_error(seq_error)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic unlock(input logic [7:0] v);
        wr(A_CMD, 8'hA5); wr(A_PROT, v); wr(A_PROT, ~v); wr(A_PROT, v);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R10 reset value", prot_value, 8'h3C);
        check("R10 reset error", {7'd0, seq_error}, 8'h00);
        rd(A_STAT, d);
        check("R5 status after reset", d, 8'h00);
        rd(A_CMD, d);
        check("R11 command reads zero", d, 8'h00);
    endtask

    task automatic t_good;
        logic [7:0] d;
        wr(A_CMD, 8'hA5); wr(A_PROT, 8'h5A); wr(A_PROT, 8'hA5);
        check("R2 no update before final write", prot_value, 8'h3C);
        wr(A_PROT, 8'h5A);
        check("R2 update on final write", prot_value, 8'h5A);
        rd(A_STAT, d);
        check("R5 status clear after success", d, 8'h00);
        rd(A_PROT, d);
        check("R11 guarded readback", d, 8'h5A);
    endtask

    task automatic t_no_key;
        wr(A_PROT, 8'h11); wr(A_PROT, 8'hEE); wr(A_PROT, 8'h11);
        check("R2 no key no update", prot_value, 8'h5A);
    endtask

    task automatic t_abort_read;
        wr(A_CMD, 8'hA5); wr(A_PROT, 8'h33);
        begin logic [7:0] d; rd(A_CMD, d); end
        check("R3 abort sets error", {7'd0, seq_error}, 8'h01);
        wr(A_PROT, 8'hCC); wr(A_PROT, 8'h33);
        check("R4 no progress kept", prot_value, 8'h5A);
        wr(A_PROT, 8'h33); wr(A_PROT, 8'hCC); wr(A_PROT, 8'h33);
        check("R4 keyless retry ignored", prot_value, 8'h5A);
        wr(A_CMD, 8'h5A);
        check("R1 wrong key keeps error", {7'd0, seq_error}, 8'h01);
        wr(A_PROT, 8'h77); wr(A_PROT, 8'h88); wr(A_PROT, 8'h77);
        check("R1 wrong key does not arm", prot_value, 8'h5A);
        wr(A_CMD, 8'hA5);
        check("R9 key clears error", {7'd0, seq_error}, 8'h00);
        wr(A_PROT, 8'h33); wr(A_PROT, 8'hCC); wr(A_PROT, 8'h33);
        check("R4 restart succeeds", prot_value, 8'h33);
    endtask

    task automatic t_abort_prot_read_and_rekey;
        logic [7:0] d;
        wr(A_CMD, 8'hA5);
        rd(A_PROT, d);
        check("R3 guarded read aborts", {7'd0, seq_error}, 8'h01);
        wr(A_CMD, 8'hA5); wr(A_PROT, 8'h44); wr(A_CMD, 8'hA5);
        check("R3 second key aborts", {7'd0, seq_error}, 8'h01);
        wr(A_PROT, 8'hBB); wr(A_PROT, 8'h44);
        check("R3 after rekey abort no update", prot_value, 8'h33);
    endtask

    task automatic t_outside;
        logic [7:0] d;
        wr(A_CMD, 8'hA5);
        wr(A_OTHER, 8'hFF); rd(A_STAT, d);
        wr(A_PROT, 8'h96);
        rd(A_OTHER, d); wr(A_STAT, 8'h01);
        wr(A_PROT, 8'h69);
        rd(A_STAT, d);
        check("R6 status read mid-sequence", d, 8'h00);
        wr(A_PROT, 8'h96);
        check("R6 outside traffic harmless", prot_value, 8'h96);
        check("R6 error clear", {7'd0, seq_error}, 8'h00);
    endtask

    task automatic t_mismatch;
        wr(A_CMD, 8'hA5); wr(A_PROT, 8'h12); wr(A_PROT, 8'hED ^ 8'h01);
        check("R8 bad complement error", {7'd0, seq_error}, 8'h01);
        wr(A_PROT, 8'h12);
        check("R8 bad complement no update", prot_value, 8'h96);
        wr(A_CMD, 8'hA5); wr(A_PROT, 8'h12); wr(A_PROT, 8'hED); wr(A_PROT, 8'h13);
        check("R8 bad final error", {7'd0, seq_error}, 8'h01);
        check("R8 bad final no update", prot_value, 8'h96);
    endtask

    task automatic t_halt;
        logic [7:0] d;
        wr(A_CMD, 8'hA5); wr(A_PROT, 8'hC3);
        @(negedge clk) dbg_halt = 1'b1;
        wr(A_PROT, 8'h00); rd(A_CMD, d); wr(A_CMD, 8'h00); wr(A_PROT, 8'hC3);
        check("R7 no error in halt", {7'd0, seq_error}, 8'h00);
        check("R7 value held in halt", prot_value, 8'h96);
        @(negedge clk) dbg_halt = 1'b0;
        wr(A_PROT, 8'h3C); wr(A_PROT, 8'hC3);
        check("R7 resumes after halt", prot_value, 8'hC3);
        check("R7 error clear after resume", {7'd0, seq_error}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_good();
        t_no_key();
        t_abort_read();
        t_abort_prot_read_and_rekey();
        t_outside();
        t_mismatch();
        t_halt();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule